// File: doc/BRIEF.md
# Phase Accumulator with Memory-Driven Frequency/Phase Routing

This block is the phase-generating front of a direct digital synthesizer. A wide phase accumulator advances by an increment every clock, and a phase offset is added to its most significant bits to form a truncated output phase word. Converting that phase to amplitude, and the converter after it, lie outside this block.

The increment and the offset each come from one of two places. The first is a pair of programmed registers: a tuning word and an offset word. The second is a word read from the modulation memory. Two control bits choose the routing. With the memory path off, the block produces a single tone from the programmed registers. With the memory path on, the memory word replaces either the tuning word, which gives frequency-shift keying, or the offset, which gives phase-shift keying. The programmed register that is not replaced keeps driving the other path.

The tuning word, offset word and both control bits are written into a staging side. They move to the active side together only on an update strobe. The memory word is used live. The accumulator is never cleared by a change of increment, so frequency hops are phase-continuous.

Top module: `dds_phase_core`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `phase_out` is 0. The accumulator and all active settings are 0, which selects single-tone routing.
- R2: On every clock edge out of reset, the 32-bit accumulator adds the selected increment modulo 2^32. It wraps without saturating.
- R3: Values on `tune_word_in`, `phase_ofs_in`, `mod_enable_in` and `mod_to_phase_in` have no effect until a clock edge at which `update_strobe` is 1. They are used from the next edge onward.
- R4: With active `mod_enable` = 0 (single tone), the increment is the active tuning word and the offset is the active offset word. The active `mod_to_phase` bit has no effect in this mode.
- R5: With active `mod_enable` = 1 and `mod_to_phase` = 0 (frequency keying), the increment is `mod_word` and the offset is the active offset word.
- R6: With active `mod_enable` = 1 and `mod_to_phase` = 1 (phase keying), the offset is `mod_word[31:18]` and the increment is the active tuning word. `mod_word[17:0]` has no effect.
- R7: A change of increment never resets the accumulator. The next phase is the current phase plus the new increment.
- R8: `phase_out` is registered. After each edge it equals (accumulator bits [31:18] + offset) mod 2^14, with both the accumulator and the offset taken as they were before that edge.
- R9: `mod_word` is not staged. A new value is used at the very next clock edge, without any update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word_in | input | 32 | Staged frequency tuning word |
| phase_ofs_in | input | 14 | Staged phase offset word |
| mod_enable_in | input | 1 | Staged memory-path enable |
| mod_to_phase_in | input | 1 | Staged destination: 0 sends the memory word to the increment, 1 sends it to the offset |
| update_strobe | input | 1 | Moves all staged values to the active set at this edge |
| mod_word | input | 32 | Memory data word, used live |
| phase_out | output | 14 | Truncated output phase |

## Verification
The assertions assume that `mod_word` and the staged inputs are settled at each rising edge. They also assume that `update_strobe` is a plain level sampled at the edge, so a strobe held high simply reloads the active set on every edge. The bench respects this by changing every input only on falling edges. It sweeps all four combinations of the two control bits, with many tuning, offset and memory words, including a wrap-forcing tuning word and a phase-keying run in which only the low memory bits change.

// File: rtl/dds_pkg.sv
// Package: shared widths and the routing-mode type for the phase core.
// Assumes the memory word has the same width as the accumulator.
package dds_pkg;
    localparam int DDS_ACC_W = 32;
    localparam int DDS_PH_W  = 14;

    // Routing of the memory word, decoded from the two active control bits.
    typedef enum logic [1:0] {
        ROUTE_TONE  = 2'd0,
        ROUTE_FREQ  = 2'd1,
        ROUTE_PHASE = 2'd2
    } route_e;

    // Decode enable/destination into a route; destination is ignored when disabled.
    function automatic route_e decode_route(input logic en, input logic to_phase);
        if (!en)
            return ROUTE_TONE;
        else if (to_phase)
            return ROUTE_PHASE;
        else
            return ROUTE_FREQ;
    endfunction
endpackage

// File: rtl/dds_ctrl_bank.sv
// Active register set: holds the tuning word, offset word and routing bits.
// It loads them from the staging inputs only on the update strobe.
// Assumes the staging inputs are settled at the rising edge.
module dds_ctrl_bank #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] ftw_stage,
    input  logic [PH_W-1:0]  pow_stage,
    input  logic             en_stage,
    input  logic             dest_stage,
    output logic [ACC_W-1:0] ftw_act,
    output logic [PH_W-1:0]  pow_act,
    output logic             en_act,
    output logic             dest_act
);
    // Transfer the staged set into the active set on update; reset selects single tone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_act  <= '0;
            pow_act  <= '0;
            en_act   <= 1'b0;
            dest_act <= 1'b0;
        end else if (load) begin
            ftw_act  <= ftw_stage;
            pow_act  <= pow_stage;
            en_act   <= en_stage;
            dest_act <= dest_stage;
        end
    end
endmodule

// File: rtl/dds_route.sv
// Source selection: picks the accumulator increment and the phase offset.
// The choice is between the active registers and the live memory word.
// The memory offset is taken from the top PH_W bits of the memory word.
module dds_route
    import dds_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input  logic             en_act,
    input  logic             dest_act,
    input  logic [ACC_W-1:0] ftw_act,
    input  logic [PH_W-1:0]  pow_act,
    input  logic [ACC_W-1:0] mem_word,
    output logic [ACC_W-1:0] incr_sel,
    output logic [PH_W-1:0]  ofs_sel
);
    localparam int MEM_LO = ACC_W - PH_W;

    route_e mode;
    logic [PH_W-1:0] mem_ofs;

    // Memory bits below MEM_LO are dropped here.
    assign mem_ofs = mem_word[ACC_W-1:MEM_LO];

    // Decode the active control bits into a routing mode.
    always_comb mode = decode_route(en_act, dest_act);

    // Steer the memory word to one path; the other path keeps its register.
    always_comb begin
        incr_sel = ftw_act;
        ofs_sel  = pow_act;
        case (mode)
            ROUTE_FREQ:  incr_sel = mem_word;
            ROUTE_PHASE: ofs_sel  = mem_ofs;
            default: ;
        endcase
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator and offset adder. The accumulator adds incr every clock
// and wraps modulo 2**ACC_W. The output phase is the registered sum of its top
// PH_W bits and the offset, modulo 2**PH_W. Assumes PH_W <= ACC_W.
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] incr,
    input  logic [PH_W-1:0]  ofs,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_q
);
    localparam int TOP_LO = ACC_W - PH_W;

    logic [PH_W-1:0] acc_top;
    assign acc_top = acc_q[ACC_W-1:TOP_LO];

    // Advance the phase; a new increment continues from the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + incr;
    end

    // Register the truncated phase plus offset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= acc_top + ofs;
    end
endmodule

// File: rtl/dds_phase_core.sv
// Top: double-buffered settings, memory routing and the phase accumulator.
// Single tone after reset. The memory word is used live; the other settings
// take effect one edge after the update strobe.
module dds_phase_core #(
    parameter int ACC_W = dds_pkg::DDS_ACC_W,
    parameter int PH_W  = dds_pkg::DDS_PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune_word_in,
    input  logic [PH_W-1:0]  phase_ofs_in,
    input  logic             mod_enable_in,
    input  logic             mod_to_phase_in,
    input  logic             update_strobe,
    input  logic [ACC_W-1:0] mod_word,
    output logic [PH_W-1:0]  phase_out
);
    logic [ACC_W-1:0] act_ftw;
    logic [PH_W-1:0]  act_pow;
    logic             act_en;
    logic             act_dest;
    logic [ACC_W-1:0] incr_sel;
    logic [PH_W-1:0]  ofs_sel;
    logic [ACC_W-1:0] acc_q;

    dds_ctrl_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (update_strobe),
        .ftw_stage (tune_word_in),
        .pow_stage (phase_ofs_in),
        .en_stage  (mod_enable_in),
        .dest_stage(mod_to_phase_in),
        .ftw_act   (act_ftw),
        .pow_act   (act_pow),
        .en_act    (act_en),
        .dest_act  (act_dest)
    );

    dds_route #(.ACC_W(ACC_W), .PH_W(PH_W)) u_route (
        .en_act  (act_en),
        .dest_act(act_dest),
        .ftw_act (act_ftw),
        .pow_act (act_pow),
        .mem_word(mod_word),
        .incr_sel(incr_sel),
        .ofs_sel (ofs_sel)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .incr   (incr_sel),
        .ofs    (ofs_sel),
        .acc_q  (acc_q),
        .phase_q(phase_out)
    );
endmodule

// File: rtl/dds_phase_core_chk.sv
// Checker for dds_phase_core. It relates the ports and the active register
// set across clock edges. It is attached to every instance by the bind at the
// end of this file.
module dds_phase_core_chk #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] tune_word_in,
    input logic [PH_W-1:0]  phase_ofs_in,
    input logic             mod_enable_in,
    input logic             mod_to_phase_in,
    input logic             update_strobe,
    input logic [ACC_W-1:0] mod_word,
    input logic [PH_W-1:0]  phase_out,
    input logic [ACC_W-1:0] act_ftw,
    input logic [PH_W-1:0]  act_pow,
    input logic             act_en,
    input logic             act_dest,
    input logic [ACC_W-1:0] acc_q
);
    localparam int TOP_LO = ACC_W - PH_W;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_out == '0 && acc_q == '0 && !act_en));

    // R3
    hold_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_strobe |=> ($stable(act_ftw) && $stable(act_pow) && $stable(act_en) && $stable(act_dest)));

    // R3
    load_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> (act_ftw == $past(tune_word_in) && act_pow == $past(phase_ofs_in)
                           && act_en == $past(mod_enable_in) && act_dest == $past(mod_to_phase_in)));

    // R4
    tone_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> acc_q == $past(acc_q + act_ftw));

    // R4
    tone_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> phase_out == $past(acc_q[ACC_W-1:TOP_LO] + act_pow));

    // R5
    freq_key_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !act_dest) |=> acc_q == $past(acc_q + mod_word));

    // R6
    phase_key_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && act_dest) |=> phase_out == $past(acc_q[ACC_W-1:TOP_LO] + mod_word[ACC_W-1:TOP_LO]));

    // R6
    phase_key_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && act_dest) |=> acc_q == $past(acc_q + act_ftw));
endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tune_word_in   (tune_word_in),
    .phase_ofs_in   (phase_ofs_in),
    .mod_enable_in  (mod_enable_in),
    .mod_to_phase_in(mod_to_phase_in),
    .update_strobe  (update_strobe),
    .mod_word       (mod_word),
    .phase_out      (phase_out),
    .act_ftw        (act_ftw),
    .act_pow        (act_pow),
    .act_en         (act_en),
    .act_dest       (act_dest),
    .acc_q          (acc_q)
);

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tune_word_in;
    logic [13:0] phase_ofs_in;
    logic        mod_enable_in;
    logic        mod_to_phase_in;
    logic        update_strobe;
    logic [31:0] mod_word;
    logic [13:0] phase_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state, computed from the requirements.
    logic [31:0] m_ftw, m_acc;
    logic [13:0] m_pow, m_phase;
    logic        m_en, m_dest;

    always #5 clk = ~clk;

    dds_phase_core uut (
        .clk(clk), .rst_n(rst_n), .tune_word_in(tune_word_in),
        .phase_ofs_in(phase_ofs_in), .mod_enable_in(mod_enable_in),
        .mod_to_phase_in(mod_to_phase_in), .update_strobe(update_strobe),
        .mod_word(mod_word), .phase_out(phase_out)
    );

    // Reference model: the increment and offset follow R4/R5/R6, the phase
    // follows R2/R8, the staging follows R3 and the live memory word R9.
    always @(posedge clk) begin
        logic [31:0] inc;
        logic [13:0] ofs;
        if (!rst_n) begin
            m_ftw <= 0; m_pow <= 0; m_en <= 0; m_dest <= 0; m_acc <= 0; m_phase <= 0;
        end else begin
            inc = (m_en && !m_dest) ? mod_word : m_ftw;
            ofs = (m_en && m_dest) ? mod_word[31:18] : m_pow;
            m_acc   <= m_acc + inc;
            m_phase <= m_acc[31:18] + ofs;
            if (update_strobe) begin
                m_ftw <= tune_word_in; m_pow <= phase_ofs_in;
                m_en <= mod_enable_in; m_dest <= mod_to_phase_in;
            end
        end
    end

    task automatic check_phase(input string req);
        checks++;
        if (phase_out !== m_phase) begin
            fails++;
            $display("FAIL %s: phase_out actual %h expected %h", req, phase_out, m_phase);
        end
    endtask

    // One clock, then compare on the falling edge.
    task automatic step(input string req);
        @(posedge clk);
        @(negedge clk);
        check_phase(req);
    endtask

    task automatic pulse_update(input string req);
        update_strobe = 1'b1;
        step(req);
        update_strobe = 1'b0;
    endtask

    function automatic string mode_tag(input logic en, input logic dest);
        if (!en) return "R4";
        return dest ? "R6" : "R5";
    endfunction

    initial begin
        rst_n = 1'b0; tune_word_in = '0; phase_ofs_in = '0; mod_enable_in = 0;
        mod_to_phase_in = 0; update_strobe = 0; mod_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_phase("R1");
        // R1: reset value must be literally zero
        checks++;
        if (phase_out !== 14'd0) begin
            fails++;
            $display("FAIL R1: phase_out actual %h expected 0000", phase_out);
        end
        // Load the staging side with junk while still in reset.
        tune_word_in = 32'h0100_0000; phase_ofs_in = 14'h0ABC;
        mod_enable_in = 1; mod_word = 32'h1234_5678;
        rst_n = 1'b1;
        // R3: no strobe, so the staged settings stay inactive and the phase stays 0
        for (int i = 0; i < 6; i++) begin
            step("R3");
            checks++;
            if (phase_out !== 14'd0) begin
                fails++;
                $display("FAIL R3: phase_out actual %h expected 0000", phase_out);
            end
        end
        // R4: single tone from the registers
        mod_enable_in = 0;
        pulse_update("R3");
        for (int i = 0; i < 20; i++) step("R4");
        // R4: the destination bit is ignored while the memory path is off
        mod_to_phase_in = 1; phase_ofs_in = 14'h1000;
        pulse_update("R4");
        for (int i = 0; i < 20; i++) begin
            mod_word = 32'hDEAD_0000 + i * 32'h0101_0101;
            step("R4");
        end
        // R2: a tuning word that forces the accumulator to wrap
        tune_word_in = 32'hFFFF_FFF0; mod_to_phase_in = 0;
        pulse_update("R2");
        for (int i = 0; i < 12; i++) step("R2");
        // Sweep of every routing mode with many words (R5, R6, R9)
        for (int md = 0; md < 4; md++) begin
            for (int p = 0; p < 8; p++) begin
                mod_enable_in   = md[1];
                mod_to_phase_in = md[0];
                tune_word_in    = 32'h9E37_79B9 * (p + 1);
                phase_ofs_in    = 14'(p * 14'h07FF);
                pulse_update("R3");
                for (int i = 0; i < 16; i++) begin
                    mod_word = 32'h85EB_CA6B * (md * 128 + p * 16 + i + 1);
                    step(md[1] ? "R9" : mode_tag(m_en, m_dest));
                    step(mode_tag(m_en, m_dest));
                end
            end
        end
        // R7: hop from a large increment to zero; the phase must freeze, not restart
        mod_enable_in = 0; tune_word_in = 32'h0333_0000;
        pulse_update("R7");
        for (int i = 0; i < 5; i++) step("R7");
        tune_word_in = 32'h0;
        pulse_update("R7");
        step("R7");
        for (int i = 0; i < 5; i++) step("R7");
        // R5: frequency keying, hop between two memory tones
        mod_enable_in = 1; mod_to_phase_in = 0; phase_ofs_in = 14'h0155;
        pulse_update("R5");
        for (int i = 0; i < 24; i++) begin
            mod_word = i[2] ? 32'h0400_0000 : 32'h0010_0000;
            step("R5");
        end
        // R6: phase keying, only the ignored low memory bits change
        mod_to_phase_in = 1; tune_word_in = 32'h0002_0000;
        pulse_update("R6");
        for (int i = 0; i < 64; i++) begin
            mod_word = {14'h2A5A, 18'(i * 18'h0_4F1B)};
            step("R6");
        end
        // R8: the offset wraps modulo 2**14
        mod_to_phase_in = 0; mod_enable_in = 0;
        phase_ofs_in = 14'h3FFF; tune_word_in = 32'h4000_0000;
        pulse_update("R8");
        for (int i = 0; i < 10; i++) step("R8");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule